// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Register Front End

This block is the digital control side of a single-channel voltage-output converter. A host presents a data word, a gain-select bit and a reference-buffer-select bit on parallel inputs. It strobes an active-low write while an active-low select is held low, and those three values are captured into a staging register. A separate active-low load strobe moves the staging register into the output register, which drives the converter code, the gain control and the reference-buffer control. Several such blocks can therefore be staged one by one and then switched together. A transfer happens only if the staging register has received a write since the last transfer.

All host strobes are asynchronous to the block clock. They pass through a two-flop synchronizer, and the write is acted on at the rising edge of its synchronized copy. An active-low clear zeroes both registers at once, without waiting for the clock, and overrides any write or load. An active-low power-down input drops the output-enable signal, so the analog output can go to high impedance, but it leaves every register as it is. After power-on reset, the code is zero, the gain is unity, the reference is unbuffered and the output is enabled.

Top module: `dac_front_end`

## Requirements
- R1: Data, gain and buffer bits are captured into the staging register at the rising edge of the synchronized write strobe, only when the synchronized select is low (0). A write edge while select is high (1) changes nothing.
- R2: While load is high (1), the output register and the `code_o`, `gain_o` and `ref_buf_o` outputs hold their value, even when the staging register is rewritten.
- R3: The output register loads only if the staging register was written after the last transfer. Asserting load again with no new write leaves the outputs unchanged.
- R4: `gain_o` and `ref_buf_o` change only through a transfer into the output register, never directly from a write.
- R5: With load held low, every accepted write reaches the outputs without any load pulse, one clock after the staging register captures it.
- R6: Clear low (0) forces the staging register, the output register and the pending-write flag to zero at once, with no clock edge needed. A write edge seen while clear is low is lost.
- R7: After power-on reset, `code_o` is 0, `gain_o` is 0 (unity gain), `ref_buf_o` is 0 (unbuffered) and `out_en_o` is 1.
- R8: Power-down low (0) drives `out_en_o` to 0 two clocks later. Register contents and outputs stay unchanged, and `out_en_o` returns to 1 after power-down goes high.
- R9: A load falling edge reaches `code_o` at the third rising clock edge after the fall (two synchronizer stages and one register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sel_n | input | 1 | Select strobe, active low |
| wr_n | input | 1 | Write strobe, active low, captured on its rising edge |
| load_n | input | 1 | Transfer strobe, active low |
| clr_n | input | 1 | Clear, active low, asynchronous |
| pd_n | input | 1 | Power-down request, active low |
| din | input | DATA_W | Parallel data word |
| gain_sel | input | 1 | 1 = double gain, 0 = unity gain |
| buf_sel | input | 1 | 1 = buffered reference, 0 = unbuffered |
| code_o | output | DATA_W | Converter code from the output register |
| gain_o | output | 1 | Gain control from the output register |
| ref_buf_o | output | 1 | Reference-buffer control from the output register |
| out_en_o | output | 1 | Output enable, 0 while powered down |

## Verification
Clear and a write edge are the two functions that collide. The bench raises the write strobe on the same half cycle that pulls clear low. The synchronized edge is detected while clear is still held, so clear wins. Correct behaviour is judged at the ports: the outputs stay at zero, and a later load pulse also leaves them at zero, which shows that the lost write left no pending transfer. Load held low while writes arrive is the second overlap: each accepted write must show up on the outputs with no load pulse.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  typedef struct packed {
    logic gain_x2;
    logic ref_buf;
  } dac_ctl_t;

  localparam dac_ctl_t CTL_POR = '{gain_x2: 1'b0, ref_buf: 1'b0};

  // Rising transition of a synchronized level.
  function automatic logic rise_of(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  // A transfer fires when load is active (low) and a fresh write waits.
  function automatic logic xfer_due(input logic load_lvl_n, input logic fresh);
    return ~load_lvl_n & fresh;
  endfunction

  // Pending flag: a new write sets it, a transfer without a write clears it.
  function automatic logic fresh_next(input logic fresh, input logic wr_evt,
                                      input logic xfer);
    return wr_evt | (fresh & ~xfer);
  endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    logic [WIDTH-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= g_stg[g-1].q;
      end
    end
  end

  assign q_o = g_stg[STAGES-1].q;

endmodule

// File: rtl/dacfe_input_reg.sv
module dacfe_input_reg
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              wr_lvl_n,
  input  logic              sel_lvl_n,
  input  logic [DATA_W-1:0] din_i,
  input  dac_ctl_t          ctl_i,
  input  logic              xfer_i,
  output logic              wr_evt_o,
  output logic              fresh_o,
  output logic [DATA_W-1:0] data_o,
  output dac_ctl_t          ctl_o
);

  logic              wr_prev;
  logic              fresh_q;
  logic [DATA_W-1:0] data_q;
  dac_ctl_t          ctl_q;

  assign wr_evt_o = rise_of(wr_lvl_n, wr_prev) & ~sel_lvl_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      wr_prev <= 1'b1;
      fresh_q <= 1'b0;
      data_q  <= '0;
      ctl_q   <= CTL_POR;
    end else begin
      wr_prev <= wr_lvl_n;
      fresh_q <= fresh_next(fresh_q, wr_evt_o, xfer_i);
      if (wr_evt_o) begin
        data_q <= din_i;
        ctl_q  <= ctl_i;
      end
    end
  end

  assign fresh_o = fresh_q;
  assign data_o  = data_q;
  assign ctl_o   = ctl_q;

  // R1: an accepted write edge lands the presented word in the staging register
  p_wr_capture_r1: assert property (@(posedge clk) disable iff (!arst_n)
    wr_evt_o |=> (data_q == $past(din_i)) && (ctl_q == $past(ctl_i)));

  // R1: without a write edge the staging register keeps its contents
  p_stage_hold_r1: assert property (@(posedge clk) disable iff (!arst_n)
    !wr_evt_o |=> $stable(data_q) && $stable(ctl_q));

endmodule

// File: rtl/dacfe_dac_reg.sv
module dacfe_dac_reg
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              arst_n,
  input  logic              load_lvl_n,
  input  logic              fresh_i,
  input  logic [DATA_W-1:0] data_i,
  input  dac_ctl_t          ctl_i,
  output logic              xfer_o,
  output logic [DATA_W-1:0] code_o,
  output dac_ctl_t          ctl_o
);

  logic [DATA_W-1:0] code_q;
  dac_ctl_t          ctl_q;

  assign xfer_o = xfer_due(load_lvl_n, fresh_i);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      code_q <= '0;
      ctl_q  <= CTL_POR;
    end else if (xfer_o) begin
      code_q <= data_i;
      ctl_q  <= ctl_i;
    end
  end

  assign code_o = code_q;
  assign ctl_o  = ctl_q;

  // R2: no transfer, no change of the converter code
  p_code_hold_r2: assert property (@(posedge clk) disable iff (!arst_n)
    !xfer_o |=> $stable(code_q));

  // R4: gain and buffer controls move only with a transfer
  p_ctl_hold_r4: assert property (@(posedge clk) disable iff (!arst_n)
    !xfer_o |=> $stable(ctl_q));

  // R3: a transfer copies the staging register as it stood
  p_xfer_copy_r3: assert property (@(posedge clk) disable iff (!arst_n)
    xfer_o |=> (code_q == $past(data_i)) && (ctl_q == $past(ctl_i)));

  // R6: while clear is held the output register reads zero
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (code_q == '0) && (ctl_q == CTL_POR));

endmodule

// File: rtl/dac_front_end.sv
module dac_front_end
  import dacfe_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              load_n,
  input  logic              clr_n,
  input  logic              pd_n,
  input  logic [DATA_W-1:0] din,
  input  logic              gain_sel,
  input  logic              buf_sel,
  output logic [DATA_W-1:0] code_o,
  output logic              gain_o,
  output logic              ref_buf_o,
  output logic              out_en_o
);

  localparam int NSTRB = 4;
  localparam int I_SEL = 0;
  localparam int I_WR  = 1;
  localparam int I_LD  = 2;
  localparam int I_PD  = 3;

  logic [NSTRB-1:0] strb_raw, strb_lvl;
  logic             arst_n;
  logic             wr_evt, fresh, xfer;
  logic [DATA_W-1:0] stage_data;
  dac_ctl_t          stage_ctl, out_ctl, in_ctl;

  // Clear and power-on reset share the register reset net; clear wins all.
  assign arst_n = rst_n & clr_n;

  assign strb_raw[I_SEL] = sel_n;
  assign strb_raw[I_WR]  = wr_n;
  assign strb_raw[I_LD]  = load_n;
  assign strb_raw[I_PD]  = pd_n;

  assign in_ctl = '{gain_x2: gain_sel, ref_buf: buf_sel};

  dacfe_sync #(
    .WIDTH  (NSTRB),
    .STAGES (SYNC_STAGES),
    .RST_VAL({NSTRB{1'b1}})
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (strb_raw),
    .q_o  (strb_lvl)
  );

  dacfe_input_reg #(.DATA_W(DATA_W)) u_stage (
    .clk      (clk),
    .arst_n   (arst_n),
    .wr_lvl_n (strb_lvl[I_WR]),
    .sel_lvl_n(strb_lvl[I_SEL]),
    .din_i    (din),
    .ctl_i    (in_ctl),
    .xfer_i   (xfer),
    .wr_evt_o (wr_evt),
    .fresh_o  (fresh),
    .data_o   (stage_data),
    .ctl_o    (stage_ctl)
  );

  dacfe_dac_reg #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .arst_n    (arst_n),
    .load_lvl_n(strb_lvl[I_LD]),
    .fresh_i   (fresh),
    .data_i    (stage_data),
    .ctl_i     (stage_ctl),
    .xfer_o    (xfer),
    .code_o    (code_o),
    .ctl_o     (out_ctl)
  );

  assign gain_o    = out_ctl.gain_x2;
  assign ref_buf_o = out_ctl.ref_buf;
  assign out_en_o  = strb_lvl[I_PD];

  // R3: a transfer with no overlapping write consumes the pending flag
  p_fresh_drop_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (xfer && !wr_evt) |=> !fresh);

  // R3: an accepted write always leaves a transfer pending
  p_fresh_set_r3: assert property (@(posedge clk) disable iff (!arst_n)
    wr_evt |=> fresh);

  // R8: power-down alone never alters the converter code
  p_pd_keeps_r8: assert property (@(posedge clk) disable iff (!arst_n)
    (!out_en_o && !xfer) |=> $stable(code_o));

endmodule

// File: tb/sim_dac_front_end.sv
module sim_dac_front_end;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, wr_n = 1'b1, load_n = 1'b1, clr_n = 1'b1, pd_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic gain_sel = 1'b0, buf_sel = 1'b0;
  logic [DW-1:0] code_o;
  logic gain_o, ref_buf_o, out_en_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit mon_en  = 1'b0;
  bit done    = 1'b0;

  // model state, packed as {gain, buf, code}
  logic [DW+1:0] m_in = '0, m_dac = '0, last_obs = '0;
  bit m_fresh = 1'b0;
  logic [DW+1:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_front_end #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .load_n(load_n),
    .clr_n(clr_n), .pd_n(pd_n), .din(din), .gain_sel(gain_sel),
    .buf_sel(buf_sel), .code_o(code_o), .gain_o(gain_o),
    .ref_buf_o(ref_buf_o), .out_en_o(out_en_o)
  );

  function automatic logic [DW+1:0] obs();
    return {gain_o, ref_buf_o, code_o};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_xfer(input string tag);
    if (m_fresh) begin
      m_fresh = 1'b0;
      if (m_in != m_dac) begin
        m_dac = m_in;
        exp_q.push_back(m_dac);
        tag_q.push_back(tag);
      end
    end
  endtask

  task automatic do_write(input logic [DW-1:0] d, input logic g, input logic b,
                          input bit selected, input string tag);
    din = d; gain_sel = g; buf_sel = b;
    sel_n = !selected; wr_n = 1'b0;
    waitn(3);
    if (selected) begin
      m_in = {g, b, d};
      m_fresh = 1'b1;
      if (!load_n) model_xfer(tag);
    end
    wr_n = 1'b1;
    waitn(4);
    sel_n = 1'b1;
    waitn(3);
  endtask

  task automatic load_pulse(input string tag);
    model_xfer(tag);
    load_n = 1'b0;
    waitn(4);
    load_n = 1'b1;
    waitn(4);
  endtask

  // scoreboard monitor: every output change must match the next expectation
  always @(negedge clk) begin
    if (mon_en && obs() != last_obs) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected output change", obs(), last_obs);
      end else begin
        logic [DW+1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(obs() == e, t, obs(), e);
      end
      last_obs = obs();
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    waitn(3);
    // R7: state held during and after power-on reset
    chk(obs() == '0, "R7 reset outputs", obs(), 0);
    rst_n = 1'b1;
    waitn(3);
    chk(obs() == '0, "R7 outputs after reset release", obs(), 0);
    chk(out_en_o == 1'b1, "R7 output enabled", out_en_o, 1);
    last_obs = obs();
    mon_en = 1'b1;

    // R2 / R4: staged write does not reach the outputs while load is high
    do_write(12'hA5C, 1'b1, 1'b1, 1'b1, "R2 staged");
    waitn(5);
    chk(code_o == '0, "R2 code held with load high", code_o, 0);
    chk({gain_o, ref_buf_o} == 2'b00, "R4 controls held until transfer",
        {gain_o, ref_buf_o}, 0);

    // R9: latency from load fall to code update
    begin
      int n = 0;
      model_xfer("R4 transfer of staged word");
      load_n = 1'b0;
      do begin
        @(posedge clk); n++;
        @(negedge clk);
      end while (code_o != 12'hA5C && n < 10);
      chk(n == 3, "R9 load-to-code latency", n, 3);
      waitn(2);
      load_n = 1'b1;
      waitn(4);
    end
    chk({gain_o, ref_buf_o} == 2'b11, "R4 controls after transfer",
        {gain_o, ref_buf_o}, 2'b11);

    // R3: second load with no new write changes nothing
    load_pulse("R3 repeated load");
    waitn(3);
    chk(code_o == 12'hA5C, "R3 no transfer without fresh write", code_o, 12'hA5C);

    // R2: rewrite staging with load high, then transfer
    do_write(12'h123, 1'b0, 1'b1, 1'b1, "R2 rewrite");
    chk(obs() == m_dac, "R2 outputs hold over rewrite", obs(), m_dac);
    load_pulse("R2 transfer of rewrite");

    // R5: load held low, writes go straight through
    load_n = 1'b0;
    waitn(4);
    do_write(12'hFFF, 1'b1, 1'b0, 1'b1, "R5 sync write max");
    chk(code_o == 12'hFFF, "R5 sync write reached output", code_o, 12'hFFF);
    do_write(12'h000, 1'b0, 1'b0, 1'b1, "R5 sync write zero");
    do_write(12'h801, 1'b1, 1'b1, 1'b1, "R5 sync write mid");
    chk(obs() == {2'b11, 12'h801}, "R5 sync result", obs(), {2'b11, 12'h801});

    // R1: write edge with select high is ignored
    do_write(12'h3C3, 1'b0, 1'b0, 1'b0, "R1 deselected");
    waitn(3);
    chk(obs() == {2'b11, 12'h801}, "R1 deselected write ignored", obs(),
        {2'b11, 12'h801});
    load_n = 1'b1;
    waitn(4);

    // R8: power-down gates enable, keeps registers
    pd_n = 1'b0;
    waitn(3);
    chk(out_en_o == 1'b0, "R8 enable dropped", out_en_o, 0);
    chk(obs() == m_dac, "R8 registers kept", obs(), m_dac);
    pd_n = 1'b1;
    waitn(3);
    chk(out_en_o == 1'b1, "R8 enable restored", out_en_o, 1);
    chk(obs() == m_dac, "R8 value after power-up", obs(), m_dac);

    // R6: clear collides with a write edge; clear wins
    din = 12'h5A5; gain_sel = 1'b1; buf_sel = 1'b1;
    sel_n = 1'b0; wr_n = 1'b0;
    waitn(3);
    exp_q.push_back('0); tag_q.push_back("R6 clear zeroes outputs");
    m_in = '0; m_dac = '0; m_fresh = 1'b0;
    clr_n = 1'b0; wr_n = 1'b1;
    waitn(5);
    sel_n = 1'b1;
    clr_n = 1'b1;
    waitn(3);
    chk(obs() == '0, "R6 write during clear lost", obs(), 0);
    load_pulse("R6 load after clear");
    chk(obs() == '0, "R6 no pending transfer after clear", obs(), 0);

    // R6: clear while load is held low
    do_write(12'h777, 1'b0, 1'b1, 1'b1, "R6 prep");
    load_pulse("R6 prep transfer");
    exp_q.push_back('0); tag_q.push_back("R6 clear with load low");
    m_in = '0; m_dac = '0; m_fresh = 1'b0;
    load_n = 1'b0;
    clr_n = 1'b0;
    waitn(4);
    clr_n = 1'b1;
    waitn(4);
    load_n = 1'b1;
    waitn(3);
    chk(obs() == '0, "R6 clear beats load", obs(), 0);

    waitn(5);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule